// File: doc/BRIEF.md
# SDRAM Command Sequencer with Periodic Refresh

This block converts single-word host transfers into command sequences on a single-data-rate SDRAM bus. The memory is four banks of 4096 rows by 256 columns of 32-bit words. After reset the sequencer waits out a power-up delay. It then precharges all banks, issues two auto-refresh commands and programs the mode register with burst length one and the selected CAS latency. Only after that does it accept work.

Each accepted request opens its row with an activate command. After the row-to-column delay it issues a read or write with auto precharge, so every access leaves its bank closed. Read data is captured from the data bus a CAS latency after the read command and returned on a one-cycle response strobe. A free-running interval counter raises a refresh request, which is served ahead of any new host request but never between an activate and its column command.

Command encodings on {cs_n, ras_n, cas_n, we_n}: mode load 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, no-op 0111.

Top module: `sdram_seq`

## Requirements
- R1: While reset is held and during the power-up delay, the bus shows no-op (0111), `sd_cke` is 1, `sd_dq_oe` is 0, and both `req_ready` and `rsp_valid` are 0.
- R2: No earlier than INIT_CYC cycles after reset, the first commands are, in this order: precharge with `sd_a[10]`=1, refresh, refresh, mode load. `req_ready` stays 0 until the mode load has been issued, and no activate precedes it.
- R3: Command spacing: precharge to next command is at least T_RP cycles, refresh to next at least T_RC, mode load to next at least 2, and activate to its read or write exactly T_RCD, with no command between them.
- R4: The activate carries bank `req_addr[23:22]` on `sd_ba` and row `req_addr[21:10]` on `sd_a`. The column command carries `req_addr[9:2]` on `sd_a[7:0]`, with `sd_a[10]`=1 (auto precharge) and `sd_a[11]`, `sd_a[9:8]` at 0. `req_addr[1:0]` has no effect.
- R5: A write drives `sd_dq_out` with the request data and `sd_dq_oe`=1 in the same cycle, with `sd_dqm` equal to the inverse of `req_be` (bit i masks byte i). `sd_dq_oe` is 0 in every other cycle.
- R6: A read drives `sd_dqm`=0. The data on `sd_dq_in` is taken CL clocks after the read is presented, and `rsp_valid` pulses for one cycle CL+1 cycles after the read command appears on the bus.
- R7: After a read or write, the next command waits at least max(T_RC−T_RCD, T_RP+2, CL+2) cycles.
- R8: After initialisation, consecutive refresh commands are REF_INT ± (T_RCD + gap of R7 + 4) cycles apart, including under continuous host load.
- R9: A pending refresh is served before any new request, and no refresh is issued while a row is open.
- R10: Every request accepted on `req_valid && req_ready` yields exactly one activate and one column command of the matching kind, in order. Reads return the last data written to that word, merged byte by byte; a never-written word returns whatever the memory holds.
- R11: `cas_lat3` (1 = CL 3, 0 = CL 2) sets the mode load word to CL in `sd_a[6:4]`, with all other bits 0 and bank 0. It also sets the read capture delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat3 | input | 1 | CAS latency select: 1 = 3, 0 = 2; held stable after reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Address: bank [23:22], row [21:10], column [9:2] |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 32 | Read data |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Row / column / mode address |
| sd_dqm | output | 4 | Byte masks |
| sd_dq_out | output | 32 | Write data to the memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 32 | Read data from the memory |

## Verification
The bench goes after the moment a refresh falls due while a request is already waiting with valid held high. A design that let the request win would starve refresh and stretch the refresh gap past its bound, and one that cut into an open row would issue a refresh with a bank still active. It runs both CAS latencies. A capture off by one cycle returns the bus filler pattern instead of stored data, and a mode word built wrongly fails the mode-load check. Partial and empty byte-enable writes followed by reads with different low address bits expose an inverted mask or a low-bit leak into the column.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    S_INIT, S_PRE, S_REF, S_MRS, S_WAIT, S_IDLE, S_ACT, S_RW
  } seq_state_e;

  function automatic logic [1:0] addr_bank(logic [23:0] a);
    return a[23:22];
  endfunction

  function automatic logic [11:0] addr_row(logic [23:0] a);
    return a[21:10];
  endfunction

  function automatic logic [7:0] addr_col(logic [23:0] a);
    return a[9:2];
  endfunction

  // burst length 1, sequential wrap, latency in bits 6:4
  function automatic logic [11:0] mode_word(logic cl3);
    return {5'b0, (cl3 ? 3'd3 : 3'd2), 1'b0, 3'b000};
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sdram_seq_reftimer.sv
module sdram_seq_reftimer #(
  parameter int REF_INT = 2600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic pend
);
  localparam int W = $clog2(REF_INT + 1);

  logic [W-1:0] cnt;
  logic         tick;

  assign tick = en && (cnt == W'(REF_INT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (!en || tick) cnt <= '0;
      else             cnt <= cnt + 1'b1;
      if (tick)        pend <= 1'b1;
      else if (ack)    pend <= 1'b0;
    end
  end

  // a second interval must never expire before the first refresh is served
  assert_no_lost_refresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !tick);

  assert_ack_only_when_due_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pend);

endmodule

// File: rtl/sdram_seq_rdcap.sv
module sdram_seq_rdcap #(
  parameter int MAX_CL = 3,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cl3,
  input  logic          rd_issue,
  input  logic [DW-1:0] dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic [MAX_CL:0] stage;
  logic            take;

  assign take = cl3 ? stage[3] : stage[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      stage     <= {stage[MAX_CL-1:0], rd_issue};
      rsp_valid <= take;
      if (take) rsp_data <= dq_in;
    end
  end

  assert_rsp_cl2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue && !cl3) |-> ##4 rsp_valid);

  assert_rsp_cl3_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue && cl3) |-> ##5 rsp_valid);

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int INIT_CYC = 20000,
  parameter int REF_INT  = 2600,
  parameter int T_RCD    = 3,
  parameter int T_RP     = 3,
  parameter int T_RC     = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cas_lat3,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [23:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_be,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        sd_cke,
  output logic        sd_cs_n,
  output logic        sd_ras_n,
  output logic        sd_cas_n,
  output logic        sd_we_n,
  output logic [1:0]  sd_ba,
  output logic [11:0] sd_a,
  output logic [3:0]  sd_dqm,
  output logic [31:0] sd_dq_out,
  output logic        sd_dq_oe,
  input  logic [31:0] sd_dq_in
);
  localparam int T_MRD = 2;
  localparam int CNT_W = $clog2(INIT_CYC + T_RC + T_RCD + T_RP + 8);

  function automatic int rw_gap(logic cl3);
    return max3(T_RC - T_RCD, T_RP + 2, (cl3 ? 3 : 2) + 2);
  endfunction

  seq_state_e       state, st_n, ret, ret_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             ir_cnt, ir_n, init_done, done_n;
  logic             lw;
  logic [23:0]      laddr;
  logic [31:0]      ldata;
  logic [3:0]       lbe;

  // named internal events
  logic             ref_pend, ref_ack, rd_issue, accept;
  sd_cmd_e          cmd_c;
  logic [1:0]       ba_c;
  logic [11:0]      a_c;
  logic [3:0]       dqm_c;
  logic             oe_c;

  logic [3:0]       cmd_q;
  logic [1:0]       ba_q;
  logic [11:0]      a_q;
  logic [3:0]       dqm_q;
  logic [31:0]      dq_q;
  logic             oe_q;

  logic             unused_addr_lo;
  assign unused_addr_lo = ^laddr[1:0];

  assign req_ready = (state == S_IDLE) && init_done && !ref_pend;
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_n     = state;
    ret_n    = ret;
    cnt_n    = cnt;
    ir_n     = ir_cnt;
    done_n   = init_done;
    cmd_c    = CMD_NOP;
    ba_c     = '0;
    a_c      = '0;
    dqm_c    = 4'hF;
    oe_c     = 1'b0;
    ref_ack  = 1'b0;
    rd_issue = 1'b0;
    case (state)
      S_INIT: begin
        if (cnt == '0) st_n = S_PRE;
        else           cnt_n = cnt - 1'b1;
      end
      S_PRE: begin
        cmd_c    = CMD_PRE;
        a_c[10]  = 1'b1;
        cnt_n    = CNT_W'(T_RP - 2);
        ret_n    = S_REF;
        st_n     = S_WAIT;
      end
      S_REF: begin
        cmd_c = CMD_REF;
        cnt_n = CNT_W'(T_RC - 2);
        st_n  = S_WAIT;
        if (init_done) begin
          ret_n   = S_IDLE;
          ref_ack = 1'b1;
        end else if (ir_cnt) begin
          ret_n = S_MRS;
        end else begin
          ir_n  = 1'b1;
          ret_n = S_REF;
        end
      end
      S_MRS: begin
        cmd_c  = CMD_MRS;
        a_c    = mode_word(cas_lat3);
        cnt_n  = CNT_W'(T_MRD - 2);
        ret_n  = S_IDLE;
        done_n = 1'b1;
        st_n   = S_WAIT;
      end
      S_WAIT: begin
        if (cnt == '0) st_n = ret;
        else           cnt_n = cnt - 1'b1;
      end
      S_IDLE: begin
        if (init_done && ref_pend) st_n = S_REF;
        else if (accept)           st_n = S_ACT;
      end
      S_ACT: begin
        cmd_c = CMD_ACT;
        ba_c  = addr_bank(laddr);
        a_c   = addr_row(laddr);
        cnt_n = CNT_W'(T_RCD - 2);
        ret_n = S_RW;
        st_n  = S_WAIT;
      end
      S_RW: begin
        cmd_c    = lw ? CMD_WR : CMD_RD;
        ba_c     = addr_bank(laddr);
        a_c      = {1'b0, 1'b1, 2'b00, addr_col(laddr)};
        dqm_c    = lw ? ~lbe : 4'h0;
        oe_c     = lw;
        rd_issue = !lw;
        cnt_n    = CNT_W'(rw_gap(cas_lat3) - 2);
        ret_n    = S_IDLE;
        st_n     = S_WAIT;
      end
      default: st_n = S_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_INIT;
      ret       <= S_IDLE;
      cnt       <= CNT_W'(INIT_CYC - 1);
      ir_cnt    <= 1'b0;
      init_done <= 1'b0;
      lw        <= 1'b0;
      laddr     <= '0;
      ldata     <= '0;
      lbe       <= '0;
      cmd_q     <= CMD_NOP;
      ba_q      <= '0;
      a_q       <= '0;
      dqm_q     <= 4'hF;
      dq_q      <= '0;
      oe_q      <= 1'b0;
    end else begin
      state     <= st_n;
      ret       <= ret_n;
      cnt       <= cnt_n;
      ir_cnt    <= ir_n;
      init_done <= done_n;
      if (accept) begin
        lw    <= req_write;
        laddr <= req_addr;
        ldata <= req_wdata;
        lbe   <= req_be;
      end
      cmd_q <= cmd_c;
      ba_q  <= ba_c;
      a_q   <= a_c;
      dqm_q <= dqm_c;
      dq_q  <= oe_c ? ldata : '0;
      oe_q  <= oe_c;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_cke    = 1'b1;
  assign sd_ba     = ba_q;
  assign sd_a      = a_q;
  assign sd_dqm    = dqm_q;
  assign sd_dq_out = dq_q;
  assign sd_dq_oe  = oe_q;

  sdram_seq_reftimer #(.REF_INT(REF_INT)) u_ref (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (init_done),
    .ack  (ref_ack),
    .pend (ref_pend)
  );

  sdram_seq_rdcap #(.MAX_CL(3), .DW(32)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cl3      (cas_lat3),
    .rd_issue (rd_issue),
    .dq_in    (sd_dq_in),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_rdata)
  );

  assert_no_act_before_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT) |-> init_done);

  assert_quiet_after_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT) |=> (cmd_q == CMD_NOP));

  assert_drive_only_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd_q == CMD_WR));

  assert_refresh_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && init_done && ref_pend) |=> (state == S_REF));

  assert_accept_opens_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state == S_ACT));

endmodule

// File: tb/tb_sdram_seq.sv
module tb_sdram_seq;
  localparam int INIT_CYC = 40;
  localparam int REF_INT  = 300;
  localparam int T_RCD    = 3;
  localparam int T_RP     = 3;
  localparam int T_RC     = 9;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                         C_NOP = 4'b0111;
  localparam logic [31:0] FILL = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cas_lat3, req_valid, req_write;
  logic [23:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_be;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;
  logic [3:0]  sd_dqm;
  logic [31:0] sd_dq_out, sd_dq_in;

  sdram_seq #(.INIT_CYC(INIT_CYC), .REF_INT(REF_INT), .T_RCD(T_RCD),
              .T_RP(T_RP), .T_RC(T_RC)) dut (
    .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  int n_chk = 0, n_fail = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dflt(int key);
    return (32'(key) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic int keyof(logic [23:0] a);
    return int'({a[23:22], a[21:10], a[9:2]});
  endfunction

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r;
    r = o;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = n[i*8 +: 8];
    return r;
  endfunction

  function automatic int tb_clv(bit c3);
    return c3 ? 3 : 2;
  endfunction

  function automatic int tb_rwg(bit c3);
    int g;
    g = T_RC - T_RCD;
    if (T_RP + 2 > g) g = T_RP + 2;
    if (tb_clv(c3) + 2 > g) g = tb_clv(c3) + 2;
    return g;
  endfunction

  typedef struct { bit w; logic [23:0] addr; logic [31:0] d; logic [3:0] be; } req_t;
  req_t         exq[$];
  logic [31:0]  rsq[$];
  logic [31:0]  sh[int];
  logic [31:0]  mem[int];

  // memory model state
  int          ncyc, step, last_cyc, last_ref, nref, rd_due, rsp_due, gap, need, k;
  logic [3:0]  last_cmd, cmd, open;
  logic [11:0] arow[4];
  logic [31:0] rd_val, ev;
  req_t        hd;

  always @(negedge clk) begin
    if (!rst_n) begin
      ncyc = 0; step = 0; open = 0; last_cyc = -100; last_cmd = C_NOP;
      last_ref = -1; nref = 0; rd_due = -1; rsp_due = -1; sd_dq_in = FILL;
      mem.delete();
    end else begin
      ncyc++;
      sd_dq_in = (ncyc == rd_due) ? rd_val : FILL;
      if (rsp_valid) begin
        chk(ncyc == rsp_due, "R6 response cycle", 32'(ncyc), 32'(rsp_due));
        if (rsq.size() > 0) begin
          ev = rsq.pop_front();
          chk(rsp_rdata == ev, "R10 read data", rsp_rdata, ev);
        end else chk(0, "R10 unexpected response", 32'd1, 32'd0);
      end else if (ncyc == rsp_due) chk(0, "R6 missing response", 32'd0, 32'd1);
      cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (sd_dq_oe) chk(cmd == C_WR, "R5 bus driven outside write", 32'(cmd), 32'(C_WR));
      if (step < 4 && req_ready) chk(0, "R2 ready before init", 32'd1, 32'd0);
      if (cmd != C_NOP) begin
        gap = ncyc - last_cyc;
        case (last_cmd)
          C_PRE: chk(gap >= T_RP, "R3 precharge spacing", 32'(gap), 32'(T_RP));
          C_REF: chk(gap >= T_RC, "R3 refresh spacing", 32'(gap), 32'(T_RC));
          C_MRS: chk(gap >= 2, "R3 mode load spacing", 32'(gap), 32'd2);
          C_ACT: chk(gap == T_RCD && (cmd == C_RD || cmd == C_WR),
                     "R3 activate to column", 32'(gap), 32'(T_RCD));
          C_RD, C_WR: begin
            need = tb_rwg(cas_lat3);
            chk(gap >= need, "R7 column recovery", 32'(gap), 32'(need));
          end
          default: ;
        endcase
        case (cmd)
          C_PRE: begin
            chk(step == 0 && sd_a[10] && ncyc >= INIT_CYC, "R2 precharge all",
                32'(step), 32'd0);
            step = 1;
          end
          C_REF: begin
            if (step == 1 || step == 2) step++;
            else if (step == 4) begin
              chk(open == 0, "R9 refresh with open row", 32'(open), 32'd0);
              if (last_ref >= 0) begin
                need = T_RCD + tb_rwg(cas_lat3) + 4;
                chk(ncyc - last_ref >= REF_INT - need && ncyc - last_ref <= REF_INT + need,
                    "R8 refresh interval", 32'(ncyc - last_ref), 32'(REF_INT));
              end
              last_ref = ncyc; nref++;
            end else chk(0, "R2 refresh out of order", 32'(step), 32'd1);
          end
          C_MRS: begin
            chk(step == 3, "R2 mode load order", 32'(step), 32'd3);
            chk(sd_a == {5'b0, 3'(tb_clv(cas_lat3)), 4'b0} && sd_ba == 0,
                "R11 mode word", 32'(sd_a), 32'({5'b0, 3'(tb_clv(cas_lat3)), 4'b0}));
            step = 4;
          end
          C_ACT: begin
            chk(step == 4, "R2 activate before init", 32'(step), 32'd4);
            chk(open[sd_ba] == 0, "R10 activate on open bank", 32'(open), 32'd0);
            if (exq.size() > 0) begin
              hd = exq[0];
              chk(sd_ba == hd.addr[23:22], "R4 bank", 32'(sd_ba), 32'(hd.addr[23:22]));
              chk(sd_a == hd.addr[21:10], "R4 row", 32'(sd_a), 32'(hd.addr[21:10]));
            end else chk(0, "R10 activate without request", 32'd1, 32'd0);
            open[sd_ba] = 1'b1;
            arow[sd_ba] = sd_a;
          end
          C_RD, C_WR: begin
            chk(open[sd_ba], "R3 column on closed bank", 32'(open), 32'd1);
            chk(sd_a[11:8] == 4'b0100, "R4 auto precharge bits", 32'(sd_a[11:8]), 32'h4);
            if (exq.size() > 0) begin
              hd = exq.pop_front();
              chk(sd_a[7:0] == hd.addr[9:2], "R4 column", 32'(sd_a[7:0]), 32'(hd.addr[9:2]));
              chk((cmd == C_WR) == hd.w, "R10 access kind", 32'(cmd), 32'(hd.w));
            end else chk(0, "R10 column without request", 32'd1, 32'd0);
            k = int'({sd_ba, arow[sd_ba], sd_a[7:0]});
            if (cmd == C_WR) begin
              chk(sd_dqm == ~hd.be, "R5 byte mask", 32'(sd_dqm), 32'(~hd.be));
              chk(sd_dq_oe && sd_dq_out == hd.d, "R5 write data", sd_dq_out, hd.d);
              mem[k] = merge(mem.exists(k) ? mem[k] : dflt(k), sd_dq_out, ~sd_dqm);
            end else begin
              chk(sd_dqm == 4'h0, "R6 read mask", 32'(sd_dqm), 32'd0);
              rd_val  = mem.exists(k) ? mem[k] : dflt(k);
              rd_due  = ncyc + tb_clv(cas_lat3);
              rsp_due = ncyc + tb_clv(cas_lat3) + 1;
            end
            open[sd_ba] = 1'b0;
          end
          default: chk(0, "R3 illegal command", 32'(cmd), 32'(C_NOP));
        endcase
        last_cyc = ncyc;
        last_cmd = cmd;
      end
    end
  end

  task automatic send(bit w, logic [23:0] ad, logic [31:0] d, logic [3:0] be);
    req_t r;
    int   kk;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = ad; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    r.w = w; r.addr = ad; r.d = d; r.be = be;
    exq.push_back(r);
    kk = keyof(ad);
    if (w) sh[kk] = merge(sh.exists(kk) ? sh[kk] : dflt(kk), d, be);
    else   rsq.push_back(sh.exists(kk) ? sh[kk] : dflt(kk));
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic phase(bit c3);
    logic [23:0] a;
    int          rs;
    rst_n = 1'b0; cas_lat3 = c3; req_valid = 1'b0;
    exq.delete(); rsq.delete(); sh.delete();
    repeat (3) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && sd_cke && !sd_dq_oe
        && !req_ready && !rsp_valid, "R1 reset state",
        32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(C_NOP));
    #2 rst_n = 1'b1;
    repeat (INIT_CYC / 2) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && !req_ready && !rsp_valid,
        "R1 quiet during power-up delay", 32'(req_ready), 32'd0);
    while (!req_ready) @(negedge clk);
    // directed corners
    send(1, 24'h40_0C01, 32'h1122_3344, 4'hF);
    send(0, 24'h40_0C02, 32'h0, 4'h0);                // low bits differ (R4)
    send(1, 24'h40_0C03, 32'hAABB_CCDD, 4'b0101);     // partial mask (R5)
    send(0, 24'h40_0C00, 32'h0, 4'h0);
    send(1, 24'hFF_FFFF, 32'h0BAD_F00D, 4'h0);        // no byte enabled
    send(0, 24'hFF_FFFC, 32'h0, 4'h0);                // default content (R10)
    // random traffic, mostly back to back to collide with refresh (R8, R9)
    for (int i = 0; i < 260; i++) begin
      rs = $urandom % 4;
      a[23:22] = 2'($urandom);
      a[21:10] = (rs == 0) ? 12'h000 : (rs == 1) ? 12'h001 : (rs == 2) ? 12'hFFF : 12'($urandom);
      a[9:2]   = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 8);
      a[1:0]   = 2'($urandom);
      send($urandom % 2 == 1, a, $urandom, 4'($urandom));
      if ($urandom % 10 >= 7) repeat ($urandom % 5) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    chk(exq.size() == 0 && rsq.size() == 0, "R10 every request served",
        32'(exq.size() + rsq.size()), 32'd0);
    chk(nref >= 3, "R8 refreshes issued under load", 32'(nref), 32'd3);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cas_lat3 = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0;
    fork
      begin
        phase(1'b0);   // R11 latency 2
        phase(1'b1);   // R11 latency 3
      end
      begin
        repeat (150000) @(posedge clk);
        chk(0, "R10 watchdog expired", 32'd0, 32'd1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule